// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block watches for software that stops servicing it. It counts on its own free-running watchdog clock, which keeps running when the core clock is gated off for sleep. If software does not restart it in time, it asks for a device reset. If the device is in sleep mode at that moment, it asks for a wake-up instead, and execution then carries on. A configuration input turns the watchdog off for good.

A single binary divider, seven stages deep, is shared between two users. With the route bit set, the divider stretches the watchdog period by 2^sel. With the route bit clear, the divider scales an event stream for a general-purpose timer, and the watchdog runs at its base period. Software restarts the watchdog with a clear strobe or a sleep strobe. Each strobe also restarts the divider when the divider belongs to the watchdog. A status flag goes low on every time-out and is set again by reset or by either strobe.

The base period is `WD_CLK_HZ * TIMEOUT_US / 1e6` watchdog clocks. The defaults give about 18 ms.

Top module: `wdog_shared_div`

## Requirements
- R1: With `div_to_wd`=1 and `div_sel`=0, the time-out follows the last accepted strobe by BASE_CNT watchdog clocks. Crossing adds between 2 and 8 watchdog clocks before the request is seen.
- R2: A time-out gives a one-core-cycle pulse on `rst_req` when `sleep_mode` is 0, or on `wake_req` when `sleep_mode` is 1. The two are never high together.
- R3: While `cfg_wd_en`=0, neither `rst_req` nor `wake_req` ever pulses. The timer route of the divider keeps working.
- R4: With `div_to_wd`=1, the period is BASE_CNT * 2^`div_sel`, where `div_sel` 0 to 7 means 1:1 up to 1:128.
- R5: With `div_to_wd`=0, the watchdog period is BASE_CNT for any value of `div_sel`.
- R6: With `div_to_wd`=0, `tmr_out` gives one watchdog-clock pulse for every 2^`div_sel` `tmr_evt` pulses. With `div_to_wd`=1, `tmr_out` stays low.
- R7: A pulse on `clr_stb` or on `sleep_stb` restarts the base counter. It also restarts the divider when `div_to_wd`=1.
- R8: `to_flag` is 1 after reset. It goes to 0 in the cycle where a request pulses. It is set to 1 by the clock edge that samples `clr_stb` or `sleep_stb`. A time-out wins over a strobe in the same cycle.
- R9: Lowering `div_sel` without a strobe can produce a time-out in less than the new period. A strobe issued together with the change gives the full new period.
- R10: During and right after reset, `rst_req`, `wake_req` and `tmr_out` are 0 and `to_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; strobes, sleep flag and requests |
| clk_wd | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wd_en | input | 1 | Configuration enable; 0 disables the watchdog |
| div_to_wd | input | 1 | Divider route: 1 watchdog, 0 general-purpose timer |
| div_sel | input | SEL_W | Divider tap select, ratio 2^div_sel |
| clr_stb | input | 1 | Clear-watchdog strobe, one core cycle |
| sleep_stb | input | 1 | Sleep-entry strobe, one core cycle |
| sleep_mode | input | 1 | 1 while the device is asleep |
| tmr_evt | input | 1 | Timer source events, watchdog clock domain |
| rst_req | output | 1 | Device-reset request pulse |
| wake_req | output | 1 | Wake-up request pulse |
| to_flag | output | 1 | Time-out status, 0 after a time-out |
| tmr_out | output | 1 | Scaled event pulses to the timer |

## Verification
A base counter or divider that holds the wrong value shows up only as a request arriving at the wrong time. The error can stay hidden for up to one full period, as long as 128 base periods, so each period is measured from the strobe to the request and checked against a narrow window. A stale divider value after the select changes shows within one base period as an early request. A wrong route shows at once, either as `tmr_out` pulses that should not be there or as a period that ignores `div_sel`. A missed strobe crossing shows as a request one period early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic {
      ROUTE_TMR = 1'b0,
      ROUTE_WD  = 1'b1
   } div_route_e;

   function automatic int unsigned base_count(input longint unsigned hz, input longint unsigned us);
      return int'((hz * us) / 64'd1_000_000);
   endfunction
endpackage

// File: rtl/wdog_sync2.sv
module wdog_sync2 #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/wdog_pulse_xfer.sv
module wdog_pulse_xfer (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic src_pulse,
   output logic dst_pulse
);
   logic tgl_src;
   logic tgl_dst;
   logic tgl_dly;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)         tgl_src <= 1'b0;
      else if (src_pulse) tgl_src <= ~tgl_src;
   end

   wdog_sync2 #(.W(1)) u_sync (
      .clk  (dst_clk),
      .rst_n(rst_n),
      .d    (tgl_src),
      .q    (tgl_dst)
   );

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) tgl_dly <= 1'b0;
      else        tgl_dly <= tgl_dst;
   end

   assign dst_pulse = tgl_dst ^ tgl_dly;
endmodule

// File: rtl/wdog_base.sv
module wdog_base #(
   parameter int CNT = 8,
   localparam int CW = (CNT > 1) ? $clog2(CNT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   output logic          ovf,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LAST = CW'(CNT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign ovf = en && !clr && (cnt == LAST);
endmodule

// File: rtl/wdog_div.sv
module wdog_div #(
   parameter int SEL_W = 3,
   localparam int DIV_W = (1 << SEL_W) - 1,
   localparam int TAPS  = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);
   logic [DIV_W-1:0] stage;
   logic [TAPS-1:0]  tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage <= '0;
      else if (clr)  stage <= '0;
      else if (step) stage <= stage + 1'b1;
   end

   assign tap[0] = 1'b1;
   for (genvar i = 1; i < TAPS; i++) begin : g_tap
      assign tap[i] = &stage[i-1:0];
   end

   assign done = step && !clr && tap[sel];
endmodule

// File: rtl/wdog_shared_div.sv
module wdog_shared_div #(
   parameter int unsigned WD_CLK_HZ  = 31250,
   parameter int unsigned TIMEOUT_US = 18000,
   parameter int          SEL_W      = 3
) (
   input  logic             clk_core,
   input  logic             clk_wd,
   input  logic             rst_n,
   input  logic             cfg_wd_en,
   input  logic             div_to_wd,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             clr_stb,
   input  logic             sleep_stb,
   input  logic             sleep_mode,
   input  logic             tmr_evt,
   output logic             rst_req,
   output logic             wake_req,
   output logic             to_flag,
   output logic             tmr_out
);
   import wdog_pkg::*;

   localparam int BASE_CNT = int'(base_count(64'(WD_CLK_HZ), 64'(TIMEOUT_US)));
   localparam int BASE_CW  = (BASE_CNT > 1) ? $clog2(BASE_CNT) : 1;

   if (BASE_CNT < 2) begin : g_bad_base
      $error("wdog_shared_div: base period below two watchdog clocks");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("wdog_shared_div: SEL_W must be 1 to 4");
   end

   div_route_e         route;
   logic               wd_clr;
   logic               base_ovf;
   logic [BASE_CW-1:0] base_cnt;
   logic               div_step;
   logic               div_clr;
   logic               div_done;
   logic               wd_to;
   logic               to_evt;

   assign route = div_route_e'(div_to_wd);

   wdog_pulse_xfer u_clr_xfer (
      .src_clk  (clk_core),
      .dst_clk  (clk_wd),
      .rst_n    (rst_n),
      .src_pulse(clr_stb | sleep_stb),
      .dst_pulse(wd_clr)
   );

   wdog_base #(.CNT(BASE_CNT)) u_base (
      .clk  (clk_wd),
      .rst_n(rst_n),
      .en   (cfg_wd_en),
      .clr  (wd_clr),
      .ovf  (base_ovf),
      .cnt  (base_cnt)
   );

   assign div_step = (route == ROUTE_WD) ? base_ovf : tmr_evt;
   assign div_clr  = (route == ROUTE_WD) && wd_clr;

   wdog_div #(.SEL_W(SEL_W)) u_div (
      .clk  (clk_wd),
      .rst_n(rst_n),
      .clr  (div_clr),
      .step (div_step),
      .sel  (div_sel),
      .done (div_done)
   );

   assign wd_to = (route == ROUTE_WD) ? div_done : base_ovf;

   always_ff @(posedge clk_wd or negedge rst_n) begin
      if (!rst_n) tmr_out <= 1'b0;
      else        tmr_out <= (route == ROUTE_TMR) && div_done;
   end

   wdog_pulse_xfer u_to_xfer (
      .src_clk  (clk_wd),
      .dst_clk  (clk_core),
      .rst_n    (rst_n),
      .src_pulse(wd_to),
      .dst_pulse(to_evt)
   );

   always_ff @(posedge clk_core or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
         to_flag  <= 1'b1;
      end else begin
         rst_req  <= to_evt && !sleep_mode;
         wake_req <= to_evt && sleep_mode;
         if (to_evt)                     to_flag <= 1'b0;
         else if (clr_stb || sleep_stb)  to_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int CW = 4
) (
   input logic          clk_core,
   input logic          clk_wd,
   input logic          rst_n,
   input logic          cfg_wd_en,
   input logic          div_to_wd,
   input logic          sleep_mode,
   input logic          clr_stb,
   input logic          sleep_stb,
   input logic          rst_req,
   input logic          wake_req,
   input logic          to_flag,
   input logic          tmr_out,
   input logic          wd_clr,
   input logic          wd_to,
   input logic          to_evt,
   input logic [CW-1:0] base_cnt
);
   p_req_excl_r2: assert property (@(posedge clk_core) disable iff (!rst_n)
      !(rst_req && wake_req));

   p_rst_when_awake_r2: assert property (@(posedge clk_core) disable iff (!rst_n)
      rst_req |-> $past(!sleep_mode));

   p_wake_when_asleep_r2: assert property (@(posedge clk_core) disable iff (!rst_n)
      wake_req |-> $past(sleep_mode));

   p_flag_low_on_req_r8: assert property (@(posedge clk_core) disable iff (!rst_n)
      (rst_req || wake_req) |-> !to_flag);

   p_flag_set_by_strobe_r8: assert property (@(posedge clk_core) disable iff (!rst_n)
      ((clr_stb || sleep_stb) && !to_evt) |=> to_flag);

   p_silent_when_off_r3: assert property (@(posedge clk_wd) disable iff (!rst_n)
      !cfg_wd_en |-> !wd_to);

   p_clear_restarts_r7: assert property (@(posedge clk_wd) disable iff (!rst_n)
      wd_clr |=> (base_cnt == '0));

   p_tmr_quiet_r6: assert property (@(posedge clk_wd) disable iff (!rst_n)
      (div_to_wd && $past(div_to_wd)) |-> !tmr_out);
endmodule

bind wdog_shared_div wdog_chk #(.CW(BASE_CW)) u_chk (
   .clk_core  (clk_core),
   .clk_wd    (clk_wd),
   .rst_n     (rst_n),
   .cfg_wd_en (cfg_wd_en),
   .div_to_wd (div_to_wd),
   .sleep_mode(sleep_mode),
   .clr_stb   (clr_stb),
   .sleep_stb (sleep_stb),
   .rst_req   (rst_req),
   .wake_req  (wake_req),
   .to_flag   (to_flag),
   .tmr_out   (tmr_out),
   .wd_clr    (wd_clr),
   .wd_to     (wd_to),
   .to_evt    (to_evt),
   .base_cnt  (base_cnt)
);

// File: tb/wdog_shared_div_tb.sv
module wdog_shared_div_tb;
   localparam int P = 8;

   typedef struct packed {
      logic [2:0] sel;
      logic       to_wd;
      logic       asleep;
      logic       via_sleep;
      logic [3:0] shift;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{3'd0, 1'b1, 1'b0, 1'b0, 4'd0},
      '{3'd3, 1'b1, 1'b0, 1'b0, 4'd3},
      '{3'd7, 1'b1, 1'b1, 1'b1, 4'd7},
      '{3'd5, 1'b0, 1'b0, 1'b0, 4'd0},
      '{3'd1, 1'b1, 1'b1, 1'b0, 4'd1},
      '{3'd2, 1'b1, 1'b0, 1'b1, 4'd2},
      '{3'd7, 1'b0, 1'b1, 1'b0, 4'd0}
   };

   logic       clk_core = 1'b0;
   logic       clk_wd = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wd_en = 1'b1;
   logic       div_to_wd = 1'b1;
   logic [2:0] div_sel = 3'd0;
   logic       clr_stb = 1'b0;
   logic       sleep_stb = 1'b0;
   logic       sleep_mode = 1'b0;
   logic       tmr_evt = 1'b0;
   logic       rst_req, wake_req, to_flag, tmr_out;

   int n_chk = 0;
   int n_err = 0;
   int unsigned wd_cyc = 0;
   int unsigned req_seen = 0;

   always #4 clk_core = ~clk_core;
   always #10 clk_wd = ~clk_wd;
   always @(posedge clk_wd) wd_cyc++;
   always @(negedge clk_core) if (rst_req || wake_req) req_seen++;

   wdog_shared_div #(.WD_CLK_HZ(1_000_000), .TIMEOUT_US(P), .SEL_W(3)) u_dut (
      .clk_core(clk_core), .clk_wd(clk_wd), .rst_n(rst_n), .cfg_wd_en(cfg_wd_en),
      .div_to_wd(div_to_wd), .div_sel(div_sel), .clr_stb(clr_stb), .sleep_stb(sleep_stb),
      .sleep_mode(sleep_mode), .tmr_evt(tmr_evt), .rst_req(rst_req), .wake_req(wake_req),
      .to_flag(to_flag), .tmr_out(tmr_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic strobe(input bit use_sleep);
      if (use_sleep) sleep_stb = 1'b1; else clr_stb = 1'b1;
      @(negedge clk_core);
      sleep_stb = 1'b0;
      clr_stb   = 1'b0;
   endtask

   task automatic wait_req(input int limit, output int unsigned diff, input int unsigned t0);
      int n = 0;
      while (!(rst_req || wake_req) && n < limit) begin
         @(negedge clk_core);
         n++;
      end
      diff = wd_cyc - t0;
   endtask

   initial begin
      repeat (150000) @(posedge clk_core);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int unsigned t0, diff, per, base_req;
      int pulses;
      string rq;
      // R10: reset state
      repeat (3) @(negedge clk_core);
      chk(rst_req == 1'b0, "R10", "rst_req in reset", rst_req, 0);
      chk(wake_req == 1'b0, "R10", "wake_req in reset", wake_req, 0);
      chk(to_flag == 1'b1, "R10", "to_flag in reset", to_flag, 1);
      rst_n = 1'b1;
      @(negedge clk_core);
      chk(tmr_out == 1'b0, "R10", "tmr_out after reset", tmr_out, 0);
      chk(to_flag == 1'b1, "R8", "to_flag after reset", to_flag, 1);

      // Vector walk: R1 R2 R4 R5 R7 R8
      foreach (VEC[i]) begin
         div_sel    = VEC[i].sel;
         div_to_wd  = VEC[i].to_wd;
         sleep_mode = VEC[i].asleep;
         t0 = wd_cyc;
         strobe(VEC[i].via_sleep);
         chk(to_flag == 1'b1, "R8", "flag set by strobe", to_flag, 1);
         per = P << VEC[i].shift;
         wait_req(int'(per) * 3 + 100, diff, t0);
         rq = VEC[i].via_sleep ? "R7" : (!VEC[i].to_wd ? "R5" : (VEC[i].shift == 0 ? "R1" : "R4"));
         chk(diff >= per + 2 && diff <= per + 8, rq, "period in wd clocks", diff, per + 5);
         chk(rst_req == !VEC[i].asleep, "R2", "rst_req choice", rst_req, !VEC[i].asleep);
         chk(wake_req == VEC[i].asleep, "R2", "wake_req choice", wake_req, VEC[i].asleep);
         chk(to_flag == 1'b0, "R8", "flag after time-out", to_flag, 0);
      end
      sleep_mode = 1'b0;

      // R3 and R6: disabled watchdog, divider given to the timer
      @(negedge clk_core);
      cfg_wd_en = 1'b0;
      div_to_wd = 1'b1;
      div_sel   = 3'd2;
      strobe(1'b0);
      repeat (10) @(negedge clk_core);
      base_req = req_seen;
      div_to_wd = 1'b0;
      pulses = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk_wd);
         if (tmr_out) pulses++;
         tmr_evt = (k < 24) && (k % 2 == 0);
      end
      chk(pulses == 3, "R6", "tmr_out pulses for 12 events at 1:4", pulses, 3);
      div_to_wd = 1'b1;
      pulses = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk_wd);
         if (tmr_out) pulses++;
         tmr_evt = (k < 24) && (k % 2 == 0);
      end
      chk(pulses == 0, "R6", "tmr_out with divider on watchdog", pulses, 0);
      repeat (300) @(negedge clk_core);
      chk(req_seen == base_req, "R3", "requests while disabled", req_seen - base_req, 0);
      cfg_wd_en = 1'b1;

      // R9: select change without and with a strobe
      @(negedge clk_core);
      div_sel = 3'd3;
      t0 = wd_cyc;
      strobe(1'b0);
      while (wd_cyc < t0 + 45) @(negedge clk_core);
      div_sel = 3'd1;
      t0 = wd_cyc;
      wait_req(300, diff, t0);
      chk(rst_req && diff < 2 * P, "R9", "early time-out after unguarded change", diff, 2 * P);
      @(negedge clk_core);
      div_sel = 3'd3;
      t0 = wd_cyc;
      strobe(1'b0);
      while (wd_cyc < t0 + 45) @(negedge clk_core);
      div_sel = 3'd1;
      t0 = wd_cyc;
      strobe(1'b0);
      wait_req(300, diff, t0);
      chk(diff >= 2 * P + 2 && diff <= 2 * P + 8, "R9", "full period after guarded change", diff, 2 * P + 5);

      // R8: sleep strobe also sets the flag again
      chk(to_flag == 1'b0, "R8", "flag low after time-out", to_flag, 0);
      strobe(1'b1);
      chk(to_flag == 1'b1, "R8", "flag set by sleep strobe", to_flag, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule